// File: doc/BRIEF.md
# Split/Joined Timer-Counter with Capture

This block is a 16-bit timer/counter made of a low 8-bit half and a high 8-bit half. A 2-bit mode field decides how the halves work together: two separate prescaled 8-bit timers, a prescaled 8-bit timer paired with an 8-bit event counter, one prescaled 16-bit timer, or one 16-bit event counter. Timers advance on a system tick enable after an 8-bit prescaler divides it. Event counting advances once for each rising edge of an external event input, which is compared against the system clock.

Each half compares its count with a match value. When the half advances while equal to that value, it returns to zero and pulses its interrupt flag for one clock. In the joined modes the full 16-bit count is compared, and only the high-half flag is used. Two capture strobes latch the current counts. In the joined modes the low-half strobe latches both bytes on the same clock edge. Software configures the block through a simple register write port.

Top module: `dual_half_timer`

## Requirements
- R1: After a synchronous reset, both counts, both capture registers and both interrupt flags read zero, the mode is 0, both prescaler limits are 0, and both match values are all ones.
- R2: In mode 0, each half advances once for every (limit+1) cycles with `sys_tick` high. It uses its own prescaler limit (low: address 1, high: address 2) and its own match value (low: address 3, high: address 4). When it advances while equal to its match value, it goes to 0, and its flag (`irq_lo` or `irq_hi`) is high for exactly the next cycle.
- R3: In mode 1, the low half is a prescaled timer as in R2, and the high half advances by exactly one for each rising edge of `evt_in`, whether or not `sys_tick` is high. A level held high counts once.
- R4: In mode 2, the halves form one 16-bit timer {cnt_hi,cnt_lo} that uses the low prescaler limit. The low half carries into the high half. When the timer advances while equal to {match_hi,match_lo}, both halves go to 0 and `irq_hi` pulses.
- R5: In mode 3, the halves form one 16-bit counter of `evt_in` rising edges with no prescaler. `sys_tick` has no effect on it.
- R6: In modes 0 and 1, `cap_lo` latches `cnt_lo` into `cap_lo_val`, and `cap_hi` latches `cnt_hi` into `cap_hi_val`. The value latched is the count just before the clock edge. Each strobe leaves the other capture register unchanged.
- R7: In modes 2 and 3, `cap_lo` latches both bytes on the same edge, so {cap_hi_val,cap_lo_val} equals the 16-bit count. `cap_hi` has no effect.
- R8: A write to the mode (address 0, bits 1:0) or to either prescaler limit clears both counters and both prescaler counts. A write to a match value does not clear them.
- R9: `irq_lo` never asserts while the mode is 2 or 3.
- R10: Writes with `wr_en` high set the register at `wr_addr`. Address 0 holds the mode, address 1 the low prescaler limit, address 2 the high prescaler limit, address 3 the low match value and address 4 the high match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick | input | 1 | Tick enable that feeds the prescalers |
| evt_in | input | 1 | External event level; each rising edge is counted |
| cap_lo | input | 1 | Low-half capture strobe (16-bit capture in joined modes) |
| cap_hi | input | 1 | High-half capture strobe (split modes only) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | HALF_W | Register write data |
| cnt_lo | output | HALF_W | Low-half count |
| cnt_hi | output | HALF_W | High-half count |
| cap_lo_val | output | HALF_W | Low capture register |
| cap_hi_val | output | HALF_W | High capture register |
| irq_lo | output | 1 | Low-half match pulse |
| irq_hi | output | 1 | High-half (or 16-bit) match pulse |

## Verification
The bench drives the carry from 0x00FF into the high byte and a 16-bit match whose low byte is not 0xFF. A design that keyed the high half only on the low-byte carry would run past the match and never wrap. It also captures in a joined mode after the high byte has moved, which exposes a design that latches only one byte or that honours the high strobe. Two further cases are rewriting a prescaler limit partway through a prescale period, and rewriting only a match value. These catch a prescaler count left standing after the write, and a clear on the wrong addresses. Event pulses and a long held level show whether a design counts edges or levels.

// File: rtl/dht_pkg.sv
package dht_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT_TMR = 2'd0,
    MODE_TMR_EVT   = 2'd1,
    MODE_JOIN_TMR  = 2'd2,
    MODE_JOIN_EVT  = 2'd3
  } dht_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_MODE     = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PS_LO    = 3'd1;
  localparam logic [ADDR_W-1:0] REG_PS_HI    = 3'd2;
  localparam logic [ADDR_W-1:0] REG_MATCH_LO = 3'd3;
  localparam logic [ADDR_W-1:0] REG_MATCH_HI = 3'd4;
endpackage

// File: rtl/dht_prescaler.sv
module dht_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            tick,
  input  logic [PS_W-1:0] limit,
  output logic            strobe
);
  logic [PS_W-1:0] pc_q;
  logic            at_limit;

  assign at_limit = (pc_q == limit);
  assign strobe   = tick && !clr && at_limit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc_q <= '0;
    end else if (tick) begin
      pc_q <= at_limit ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/dht_edge_det.sv
module dht_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din && !din_q;
endmodule

// File: rtl/dht_half_cnt.sv
module dht_half_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic         wrap,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PS_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_tick,
  input  logic              evt_in,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic [HALF_W-1:0] cap_lo_val,
  output logic [HALF_W-1:0] cap_hi_val,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int NUM_HALF = 2;
  localparam int FULL_W   = 2 * HALF_W;

  dht_mode_e       mode_q;
  logic [PS_W-1:0] ps_limit [NUM_HALF];
  logic [HALF_W-1:0] match_lo_q, match_hi_q;
  logic [NUM_HALF-1:0] ps_strobe;
  logic cfg_clr, joined, evt_rise;
  logic lo_adv, hi_adv, wrap_lo, wrap_hi, full_hit, lo_top;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_SPLIT_TMR;
      ps_limit[0] <= '0;
      ps_limit[1] <= '0;
      match_lo_q  <= '1;
      match_hi_q  <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        REG_MODE:     mode_q      <= dht_mode_e'(wr_data[1:0]);
        REG_PS_LO:    ps_limit[0] <= wr_data[PS_W-1:0];
        REG_PS_HI:    ps_limit[1] <= wr_data[PS_W-1:0];
        REG_MATCH_LO: match_lo_q  <= wr_data;
        REG_MATCH_HI: match_hi_q  <= wr_data;
        default: ;
      endcase
    end
  end

  assign cfg_clr = wr_en && (wr_addr == REG_MODE || wr_addr == REG_PS_LO ||
                             wr_addr == REG_PS_HI);
  assign joined  = mode_q[1];

  // one prescaler per half
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_ps
    dht_prescaler #(.PS_W(PS_W)) u_ps (
      .clk   (clk),
      .rst   (rst),
      .clr   (cfg_clr),
      .tick  (sys_tick),
      .limit (ps_limit[h]),
      .strobe(ps_strobe[h])
    );
  end

  dht_edge_det u_evt (
    .clk (clk),
    .rst (rst),
    .din (evt_in),
    .rise(evt_rise)
  );

  // advance and wrap decisions
  assign full_hit = ({cnt_hi, cnt_lo} == FULL_W'({match_hi_q, match_lo_q}));
  assign lo_top   = &cnt_lo;
  assign lo_adv   = (mode_q == MODE_JOIN_EVT) ? evt_rise : ps_strobe[0];

  always_comb begin
    case (mode_q)
      MODE_SPLIT_TMR: hi_adv = ps_strobe[1];
      MODE_TMR_EVT:   hi_adv = evt_rise;
      default:        hi_adv = lo_adv && (lo_top || full_hit);
    endcase
  end

  assign wrap_lo = joined ? full_hit : (cnt_lo == match_lo_q);
  assign wrap_hi = joined ? full_hit : (cnt_hi == match_hi_q);

  dht_half_cnt #(.W(HALF_W)) u_lo (
    .clk (clk),
    .rst (rst),
    .clr (cfg_clr),
    .adv (lo_adv),
    .wrap(wrap_lo),
    .cnt (cnt_lo)
  );

  dht_half_cnt #(.W(HALF_W)) u_hi (
    .clk (clk),
    .rst (rst),
    .clr (cfg_clr),
    .adv (hi_adv),
    .wrap(wrap_hi),
    .cnt (cnt_hi)
  );

  // match pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= !cfg_clr && !joined && lo_adv && wrap_lo;
      irq_hi <= !cfg_clr && hi_adv && wrap_hi;
    end
  end

  // capture registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo_val <= '0;
      cap_hi_val <= '0;
    end else begin
      if (cap_lo) cap_lo_val <= cnt_lo;
      if ((cap_lo && joined) || (cap_hi && !joined)) cap_hi_val <= cnt_hi;
    end
  end
endmodule

// File: rtl/dht_checker.sv
module dht_checker
  import dht_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_bits,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cap_lo,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic [HALF_W-1:0] cap_lo_val,
  input logic [HALF_W-1:0] cap_hi_val,
  input logic              irq_lo,
  input logic              irq_hi
);
  a_r9_no_lo_irq_joined: assert property (@(posedge clk) disable iff (rst)
    mode_bits[1] |-> !irq_lo);

  a_r8_cfg_write_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr <= REG_PS_HI) |=> (cnt_lo == '0 && cnt_hi == '0));

  a_r7_coherent_capture: assert property (@(posedge clk) disable iff (rst)
    (cap_lo && mode_bits[1]) |=> ({cap_hi_val, cap_lo_val} == $past({cnt_hi, cnt_lo})));

  a_r2_irq_hi_at_zero: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> (cnt_hi == '0));

  a_r3_event_single_step: assert property (@(posedge clk) disable iff (rst)
    (mode_bits == 2'd1 && $past(mode_bits) == 2'd1 && cnt_hi != $past(cnt_hi))
      |-> (cnt_hi == HALF_W'($past(cnt_hi) + 1'b1) || cnt_hi == '0));
endmodule

bind dual_half_timer dht_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_bits (mode_q),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .cap_lo    (cap_lo),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .cap_lo_val(cap_lo_val),
  .cap_hi_val(cap_hi_val),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi)
);

// File: tb/tb_dual_half_timer.sv
module tb_dual_half_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_tick = 1'b0, evt_in = 1'b0, cap_lo = 1'b0, cap_hi = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_lo, cnt_hi, cap_lo_val, cap_hi_val;
  logic       irq_lo, irq_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  dual_half_timer dut (
    .clk(clk), .rst(rst), .sys_tick(sys_tick), .evt_in(evt_in),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .cap_lo_val(cap_lo_val), .cap_hi_val(cap_hi_val),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  psl;
    logic [7:0]  psh;
    logic [7:0]  ml;
    logic [7:0]  mh;
    logic [15:0] n;
    logic [7:0]  el;
    logic [7:0]  eh;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd0, 8'd2, 8'd9,   8'd255, 16'd25,  8'd5,  8'd8},
    '{2'd0, 8'd3, 8'd0, 8'd255, 8'd4,   16'd17,  8'd4,  8'd2},
    '{2'd2, 8'd0, 8'd0, 8'd5,   8'd1,   16'd300, 8'd38, 8'd0},
    '{2'd2, 8'd1, 8'd0, 8'd255, 8'd255, 16'd600, 8'd44, 8'd1},
    '{2'd1, 8'd4, 8'd0, 8'd255, 8'd255, 16'd23,  8'd4,  8'd0},
    '{2'd3, 8'd0, 8'd0, 8'd255, 8'd255, 16'd23,  8'd0,  8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [7:0] pl, input logic [7:0] ph,
                     input logic [7:0] ml, input logic [7:0] mh);
    wr(3'd3, ml); wr(3'd4, mh); wr(3'd1, pl); wr(3'd2, ph); wr(3'd0, {6'd0, m});
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    sys_tick = 1'b1;
    repeat (n) @(negedge clk);
    sys_tick = 1'b0;
  endtask

  task automatic evts(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
    end
  endtask

  task automatic strobe_lo();
    @(negedge clk); cap_lo = 1'b1;
    @(negedge clk); cap_lo = 1'b0;
  endtask

  task automatic strobe_hi();
    @(negedge clk); cap_hi = 1'b1;
    @(negedge clk); cap_hi = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt_lo", cnt_lo, 0);
    chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 cap_lo_val", cap_lo_val, 0);
    chk("R1 cap_hi_val", cap_hi_val, 0);
    chk("R1 irq_lo", irq_lo, 0);
    chk("R1 irq_hi", irq_hi, 0);

    // R10 table walk across modes (R2 R4 R3 R5 counts)
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v].mode, VEC[v].psl, VEC[v].psh, VEC[v].ml, VEC[v].mh);
      ticks(int'(VEC[v].n));
      chk($sformatf("R10 vec%0d cnt_lo", v), cnt_lo, int'(VEC[v].el));
      chk($sformatf("R10 vec%0d cnt_hi", v), cnt_hi, int'(VEC[v].eh));
    end

    // R2 match pulse in mode 0
    cfg(2'd0, 8'd0, 8'd0, 8'd3, 8'd255);
    ticks(4);
    chk("R2 irq_lo pulse", irq_lo, 1);
    chk("R2 cnt_lo wrapped", cnt_lo, 0);
    chk("R2 cnt_hi", cnt_hi, 4);
    chk("R2 irq_hi quiet", irq_hi, 0);
    @(negedge clk);
    chk("R2 irq_lo one cycle", irq_lo, 0);

    // R3 events in mode 1
    cfg(2'd1, 8'd0, 8'd0, 8'd255, 8'd255);
    evts(5);
    chk("R3 five edges", cnt_hi, 5);
    chk("R3 low idle", cnt_lo, 0);
    @(negedge clk); evt_in = 1'b1;
    repeat (10) @(negedge clk);
    evt_in = 1'b0;
    @(negedge clk);
    chk("R3 held level once", cnt_hi, 6);

    // R5 mode 3 event count, tick ignored
    cfg(2'd3, 8'd0, 8'd0, 8'd255, 8'd255);
    evts(260);
    chk("R5 cnt_hi", cnt_hi, 1);
    chk("R5 cnt_lo", cnt_lo, 4);
    ticks(10);
    chk("R5 tick ignored", cnt_lo, 4);

    // R4 and R9 16-bit match with low byte not all ones
    cfg(2'd2, 8'd0, 8'd0, 8'd2, 8'd1);
    ticks(259);
    chk("R4 irq_hi", irq_hi, 1);
    chk("R4 cnt_lo", cnt_lo, 0);
    chk("R4 cnt_hi", cnt_hi, 0);
    chk("R9 irq_lo joined", irq_lo, 0);

    // R6 split capture
    cfg(2'd0, 8'd0, 8'd0, 8'd255, 8'd255);
    ticks(7);
    strobe_lo();
    chk("R6 cap_lo_val", cap_lo_val, 7);
    ticks(3);
    strobe_hi();
    chk("R6 cap_hi_val", cap_hi_val, 10);
    chk("R6 cap_lo_val held", cap_lo_val, 7);

    // R7 joined capture
    cfg(2'd2, 8'd0, 8'd0, 8'd255, 8'd255);
    ticks(300);
    strobe_lo();
    chk("R7 cap_hi_val", cap_hi_val, 1);
    chk("R7 cap_lo_val", cap_lo_val, 44);
    ticks(5);
    strobe_hi();
    chk("R7 cap_hi ignored hi", cap_hi_val, 1);
    chk("R7 cap_hi ignored lo", cap_lo_val, 44);

    // R8 clearing rules
    cfg(2'd0, 8'd3, 8'd0, 8'd255, 8'd255);
    ticks(2);
    chk("R8 pre hi", cnt_hi, 2);
    wr(3'd3, 8'd255);
    chk("R8 match write keeps", cnt_hi, 2);
    wr(3'd1, 8'd3);
    chk("R8 ps write clears", cnt_hi, 0);
    ticks(3);
    chk("R8 prescale count cleared", cnt_lo, 0);
    ticks(1);
    chk("R8 prescale restart", cnt_lo, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule